// File: doc/BRIEF.md
# RAM ECC Error Capture Unit

This block sits beside the ECC checker of an on-chip RAM and keeps a record of the most recent ECC event that software has asked to see. The checker raises one of two strobes for the access it is looking at. One strobe marks a single-bit error that was corrected. The other marks a multi-bit error that could not be corrected. Along with the strobe the block receives the access address, the data, and the bus-master attributes of the access: direction, transfer size and protection code. Two report-enable inputs, driven from a configuration register elsewhere, decide which event classes are recorded.

On an enabled event, the block loads the address, a packed 8-bit attribute word and the data into capture registers, and it sets a sticky flag for the error class. A small register read port returns the captured values. The status flags are cleared by writing 1 to the flag bit. The capture registers have no reset, so their contents are meaningful only after the first enabled event. The data captured on an uncorrectable error has no defined meaning, so the block stores zero in that case.

Top module: `ram_ecc_capture`

## Requirements
- R1: An event whose class has its report enable low changes no capture register and no status flag.
- R2: On a clock edge where an enabled event strobe is high, the access address and data are stored. They read back from offset 1 (address) and offset 3 (data) on the following cycle. Each enabled event replaces the previous capture.
- R3: An enabled corrected event sets status bit 0 at offset 0, and the flag stays set until it is cleared.
- R4: An enabled uncorrectable event sets status bit 1 at offset 0, and the flag stays set until it is cleared.
- R5: The attribute word at offset 2 holds the write indicator in bit 0 (1 = write), the 3-bit size code in bits 3:1 (000 = 8-bit, 001 = 16-bit, 010 = 32-bit, 1xx reserved but stored unchanged) and the 4-bit protection code in bits 7:4 (bit 4 data/fetch, bit 5 supervisor/user, bit 6 bufferable, bit 7 cacheable). Bits above 7 read 0.
- R6: When both classes are enabled and strobe in the same cycle, both flags are set and the capture is taken as an uncorrectable event.
- R7: Writing offset 0 clears each status flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R8: A flag that is set by an event in the same cycle as a write-1 clear of that flag ends up set.
- R9: Writes to offsets 1, 2 and 3 are ignored.
- R10: After reset both status flags read 0. Offsets 4 to 7 read 0, and status bits above 1 read 0.
- R11: A capture taken as an uncorrectable event stores zero in the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the status flags |
| cfg_rpt_corr | input | 1 | Report enable for corrected single-bit events |
| cfg_rpt_uncorr | input | 1 | Report enable for uncorrectable multi-bit events |
| ecc_corr | input | 1 | Corrected single-bit event strobe |
| ecc_uncorr | input | 1 | Uncorrectable multi-bit event strobe |
| acc_addr | input | 32 | Address of the access under check |
| acc_write | input | 1 | Access direction, 1 = write |
| acc_size | input | 3 | Transfer size code of the access |
| acc_prot | input | 4 | Protection code of the access |
| acc_data | input | 32 | Data of the access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
The case hardest to reach from the ports is a cycle in which both error classes are enabled and strobe together while software writes 1 to clear the same flags. In that cycle the priority rule and the set-over-clear rule both act at one edge. The random stimulus makes each strobe, each enable and each status write independent, so these collisions happen many times. Directed steps also force one collision explicitly. A disabled event and writes to the read-only offsets are forced in the same way. All four registers are read back after every edge.

// File: rtl/ram_ecc_cap_pkg.sv
package ram_ecc_cap_pkg;

   typedef enum logic [1:0] {
      EVC_NONE    = 2'd0,
      EVC_CORR    = 2'd1,
      EVC_UNCORR  = 2'd2
   } ev_class_e;

   localparam int unsigned OFS_STATUS = 0;
   localparam int unsigned OFS_ADDR   = 1;
   localparam int unsigned OFS_ATTR   = 2;
   localparam int unsigned OFS_DATA   = 3;

   localparam int unsigned FLAG_CORR   = 0;
   localparam int unsigned FLAG_UNCORR = 1;
   localparam int unsigned NUM_FLAGS   = 2;

endpackage

// File: rtl/ecc_event_arbiter.sv
module ecc_event_arbiter
   import ram_ecc_cap_pkg::*;
(
   input  logic      en_corr,
   input  logic      en_uncorr,
   input  logic      ev_corr,
   input  logic      ev_uncorr,
   output logic      set_corr,
   output logic      set_uncorr,
   output logic      take,
   output ev_class_e take_class
);

   always_comb begin
      set_corr   = ev_corr & en_corr;
      set_uncorr = ev_uncorr & en_uncorr;
      take       = set_corr | set_uncorr;
      // uncorrectable wins the capture slot (R6)
      if (set_uncorr)    take_class = EVC_UNCORR;
      else if (set_corr) take_class = EVC_CORR;
      else               take_class = EVC_NONE;
   end

endmodule

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank
   import ram_ecc_cap_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned SIZE_W        = 3,
   parameter int unsigned PROT_W        = 4,
   parameter bit          UNCORR_ZERO   = 1'b1,
   localparam int unsigned ATTR_W       = 1 + SIZE_W + PROT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  ev_class_e         take_class,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [PROT_W-1:0] acc_prot,
   input  logic [DATA_W-1:0] acc_data,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [ATTR_W-1:0] cap_attr,
   output logic [DATA_W-1:0] cap_data
);

   logic [ATTR_W-1:0] attr_word;
   logic [DATA_W-1:0] data_next;

   // packing: write in bit 0, size above it, protection on top
   assign attr_word = {acc_prot, acc_size, acc_write};

   generate
      if (UNCORR_ZERO) begin : g_zero_uncorr
         assign data_next = (take_class == EVC_UNCORR) ? '0 : acc_data;
      end else begin : g_raw_data
         assign data_next = acc_data;
      end
   endgenerate

   // no reset: contents are meaningful only after the first capture
   always_ff @(posedge clk) begin
      if (take) begin
         cap_addr <= acc_addr;
         cap_attr <= attr_word;
         cap_data <= data_next;
      end
   end

   p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(cap_addr) && $stable(cap_attr) && $stable(cap_data)));

   p_addr_captured_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cap_addr == $past(acc_addr)));

   p_attr_write_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cap_attr[0] == $past(acc_write)));

   p_attr_prot_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cap_attr[ATTR_W-1 -: PROT_W] == $past(acc_prot)));

   generate
      if (UNCORR_ZERO) begin : g_chk_zero
         p_uncorr_data_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (take && take_class == EVC_UNCORR) |=> (cap_data == '0));
      end
   endgenerate

endmodule

// File: rtl/ecc_status_flags.sv
module ecc_status_flags #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_stb,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] flags
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic clr_i;
         assign clr_i = clr_stb & clr_mask[i];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (set[i])  flags[i] <= 1'b1;   // set beats clear (R8)
            else if (clr_i)   flags[i] <= 1'b0;
         end

         p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);

         p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set[i]) |=> !flags[i]);

         p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i && !set[i]) |=> $stable(flags[i]));
      end
   endgenerate

endmodule

// File: rtl/ecc_reg_read.sv
module ecc_reg_read
   import ram_ecc_cap_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ATTR_W = 8,
   parameter int unsigned REG_AW = 3
) (
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [NUM_FLAGS-1:0] flags,
   input  logic [ADDR_W-1:0]    cap_addr,
   input  logic [ATTR_W-1:0]    cap_attr,
   input  logic [DATA_W-1:0]    cap_data,
   output logic [DATA_W-1:0]    reg_rdata
);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(OFS_STATUS))
         reg_rdata[NUM_FLAGS-1:0] = flags;
      else if (reg_addr == REG_AW'(OFS_ADDR))
         reg_rdata[ADDR_W-1:0] = cap_addr;
      else if (reg_addr == REG_AW'(OFS_ATTR))
         reg_rdata[ATTR_W-1:0] = cap_attr;
      else if (reg_addr == REG_AW'(OFS_DATA))
         reg_rdata = cap_data;
   end

endmodule

// File: rtl/ram_ecc_capture.sv
module ram_ecc_capture
   import ram_ecc_cap_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SIZE_W      = 3,
   parameter int unsigned PROT_W      = 4,
   parameter int unsigned REG_AW      = 3,
   parameter bit          UNCORR_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_rpt_corr,
   input  logic              cfg_rpt_uncorr,
   input  logic              ecc_corr,
   input  logic              ecc_uncorr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [PROT_W-1:0] acc_prot,
   input  logic [DATA_W-1:0] acc_data,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int unsigned ATTR_W = 1 + SIZE_W + PROT_W;

   generate
      if (ATTR_W > DATA_W) begin : g_bad_attr
         $error("attribute word wider than register data");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("address wider than register data");
      end
      if ((1 << REG_AW) <= OFS_DATA) begin : g_bad_aw
         $error("register offset too narrow for the map");
      end
   endgenerate

   logic                 set_corr, set_uncorr, take;
   ev_class_e            take_class;
   logic [ADDR_W-1:0]    cap_addr;
   logic [ATTR_W-1:0]    cap_attr;
   logic [DATA_W-1:0]    cap_data;
   logic [NUM_FLAGS-1:0] flags, set_vec;
   logic                 status_wr;
   logic                 unused_wbits;

   assign unused_wbits = ^reg_wdata[DATA_W-1:NUM_FLAGS];

   ecc_event_arbiter u_arb (
      .en_corr    (cfg_rpt_corr),
      .en_uncorr  (cfg_rpt_uncorr),
      .ev_corr    (ecc_corr),
      .ev_uncorr  (ecc_uncorr),
      .set_corr   (set_corr),
      .set_uncorr (set_uncorr),
      .take       (take),
      .take_class (take_class)
   );

   ecc_capture_bank #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .SIZE_W      (SIZE_W),
      .PROT_W      (PROT_W),
      .UNCORR_ZERO (UNCORR_ZERO)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .take_class (take_class),
      .acc_addr   (acc_addr),
      .acc_write  (acc_write),
      .acc_size   (acc_size),
      .acc_prot   (acc_prot),
      .acc_data   (acc_data),
      .cap_addr   (cap_addr),
      .cap_attr   (cap_attr),
      .cap_data   (cap_data)
   );

   assign set_vec[FLAG_CORR]   = set_corr;
   assign set_vec[FLAG_UNCORR] = set_uncorr;
   assign status_wr = reg_wr && (reg_addr == REG_AW'(OFS_STATUS));

   ecc_status_flags #(.N(NUM_FLAGS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (set_vec),
      .clr_stb  (status_wr),
      .clr_mask (reg_wdata[NUM_FLAGS-1:0]),
      .flags    (flags)
   );

   ecc_reg_read #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .ATTR_W (ATTR_W),
      .REG_AW (REG_AW)
   ) u_rd (
      .reg_addr  (reg_addr),
      .flags     (flags),
      .cap_addr  (cap_addr),
      .cap_attr  (cap_attr),
      .cap_data  (cap_data),
      .reg_rdata (reg_rdata)
   );

   p_disabled_no_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ecc_corr && cfg_rpt_corr) && !(ecc_uncorr && cfg_rpt_uncorr) && !status_wr)
      |=> $stable(flags));

   p_both_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_corr && cfg_rpt_corr && ecc_uncorr && cfg_rpt_uncorr) |=> (flags == 2'b11));

   p_uncorr_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_uncorr && cfg_rpt_uncorr) |=> flags[FLAG_UNCORR]);

endmodule

// File: tb/ram_ecc_capture_bench.sv
module ram_ecc_capture_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_rpt_corr = 0, cfg_rpt_uncorr = 0;
   logic        ecc_corr = 0, ecc_uncorr = 0;
   logic [31:0] acc_addr = 0, acc_data = 0;
   logic        acc_write = 0;
   logic [2:0]  acc_size = 0;
   logic [3:0]  acc_prot = 0;
   logic        reg_wr = 0;
   logic [2:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;

   int unsigned n_vec = 0, n_bad = 0;
   bit          done = 0;

   logic [1:0]  m_flags;
   logic [31:0] m_addr, m_data;
   logic [7:0]  m_attr;
   bit          m_valid;

   always #10 clk = ~clk;

   ram_ecc_capture u_ram_ecc_capture (
      .clk(clk), .rst_n(rst_n),
      .cfg_rpt_corr(cfg_rpt_corr), .cfg_rpt_uncorr(cfg_rpt_uncorr),
      .ecc_corr(ecc_corr), .ecc_uncorr(ecc_uncorr),
      .acc_addr(acc_addr), .acc_write(acc_write), .acc_size(acc_size),
      .acc_prot(acc_prot), .acc_data(acc_data),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   function automatic logic [7:0] pack_attr(logic w, logic [2:0] s, logic [3:0] p);
      return {p, s, w};
   endfunction

   function automatic logic [1:0] next_flags(logic [1:0] f, logic [1:0] set,
                                             logic wr, logic [2:0] a, logic [31:0] wd);
      logic [1:0] clr;
      clr = (wr && a == 3'd0) ? wd[1:0] : 2'b00;
      return (f & ~clr) | set;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic read_at(logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   // checks every register against the model; called between edges
   task automatic check_all(string tag);
      logic [31:0] v;
      reg_wr = 0;
      read_at(3'd0, v); chk({tag, " R3 R4 R7 status"}, v, {30'd0, m_flags});
      if (m_valid) begin
         read_at(3'd1, v); chk({tag, " R2 address"}, v, m_addr);
         read_at(3'd2, v); chk({tag, " R5 attributes"}, v, {24'd0, m_attr});
         read_at(3'd3, v); chk({tag, " R2 R11 data"}, v, m_data);
      end
   endtask

   // drives one cycle of stimulus, steps one edge and updates the model
   task automatic step(logic ec, logic eu, logic enc, logic enu,
                       logic wr, logic [2:0] wa, logic [31:0] wd);
      logic [1:0] set;
      ecc_corr = ec; ecc_uncorr = eu; cfg_rpt_corr = enc; cfg_rpt_uncorr = enu;
      acc_addr = $urandom; acc_data = $urandom;
      acc_write = 1'($urandom); acc_size = 3'($urandom); acc_prot = 4'($urandom);
      reg_wr = wr; reg_addr = wa; reg_wdata = wd;
      set = {eu & enu, ec & enc};
      @(posedge clk);
      m_flags = next_flags(m_flags, set, wr, wa, wd);
      if (set != 2'b00) begin
         m_valid = 1;
         m_addr  = acc_addr;
         m_attr  = pack_attr(acc_write, acc_size, acc_prot);
         m_data  = set[1] ? 32'd0 : acc_data;
      end
      @(negedge clk);
      ecc_corr = 0; ecc_uncorr = 0; reg_wr = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_vec++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] v;
      void'($urandom(32'h5eed_0c0d));
      m_flags = 0; m_valid = 0; m_addr = 0; m_attr = 0; m_data = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R10 reset state and unused offsets
      read_at(3'd0, v); chk("R10 status after reset", v, 32'd0);
      for (int a = 4; a < 8; a++) begin
         read_at(3'(a), v); chk("R10 unmapped offset", v, 32'd0);
      end

      // R2 R5 corrected capture, with specific attribute layout
      ecc_corr = 1; cfg_rpt_corr = 1; cfg_rpt_uncorr = 1;
      acc_addr = 32'h0000_1234; acc_data = 32'hCAFE_F00D;
      acc_write = 1; acc_size = 3'b010; acc_prot = 4'b1010;
      @(posedge clk);
      m_flags = 2'b01; m_valid = 1; m_addr = 32'h0000_1234;
      m_attr = 8'hA5; m_data = 32'hCAFE_F00D;
      @(negedge clk); ecc_corr = 0;
      check_all("directed corr");
      read_at(3'd2, v); chk("R5 literal attribute A5", v, 32'h0000_00A5);

      // R1 disabled uncorrectable event
      step(0, 1, 1, 0, 0, 3'd0, 0);
      check_all("R1 disabled");

      // R9 writes to capture offsets
      for (int a = 1; a < 4; a++) begin
         step(0, 0, 1, 1, 1, 3'(a), 32'hFFFF_FFFF);
         check_all("R9 write ignored");
      end

      // R6 both classes together, data zero (R11)
      step(1, 1, 1, 1, 0, 3'd0, 0);
      check_all("R6 both");
      read_at(3'd3, v); chk("R11 uncorr data zero", v, 32'd0);

      // R7 partial clear, then R8 set beats clear
      step(0, 0, 1, 1, 1, 3'd0, 32'h0000_0002);
      check_all("R7 clear bit1");
      step(1, 0, 1, 1, 1, 3'd0, 32'h0000_0003);
      check_all("R8 set beats clear");

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 10) < 3, ($urandom % 10) < 2,
              ($urandom % 4) != 0, ($urandom % 4) != 0,
              ($urandom % 10) < 3, 3'($urandom % 5), $urandom);
         check_all("random");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule